// File: doc/BRIEF.md
# Dual Calendar Alarm with Field Masks

This block watches the running time of a calendar counter and raises alarms when it matches programmed values. It holds two independent alarm register sets. Each set stores a value for seconds, minutes, hours, date, month and day-of-week, and has one enable bit per field. A field whose enable is clear is left out of the compare. With the enables, one alarm can fire at a single exact instant, such as 05:23 on the 21st of March. It can also recur, for example every minute or on every Tuesday.

The compare is evaluated once per second, on the strobe that the calendar counter supplies. A hit sets a sticky per-alarm flag. The host polls the flag and clears it with a write-one-to-clear strobe. Each alarm also has an interrupt enable. The enabled alarms drive one shared active-low interrupt line, modelled as the pull-low control of an open-drain pad. In latched mode the line stays low while any enabled flag is set. In pulse mode every enabled hit drives it low for a fixed number of clock cycles, and then it is released.

Top module: `cal_alarm_pair`

## Requirements
- R1: When the per-second strobe is high and every enabled field of an alarm equals the current time, that alarm's flag is 1 after the clock edge at which the strobe was sampled. A mismatch in any enabled field leaves the flag at 0. Time vector layout, LSB first: seconds [5:0], minutes [11:6], hours [16:12], date [21:17], month [25:22], day-of-week [28:26].
- R2: A field whose enable bit is 0 takes no part in the compare. The enable bits are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week. With only the seconds bit set, the alarm fires at each matching second whatever the other fields hold.
- R3: An alarm with all six enable bits at 0 never sets its flag, even when its stored value equals the current time.
- R4: Without the strobe, a matching time does not set a flag.
- R5: A flag stays set until a 1 is written to its bit of the clear strobe. A clear aimed at the other alarm has no effect on it. If a hit and a clear of the same alarm come in the same cycle, the flag ends set.
- R6: The two alarms are independent. A hit sets only the flag of the alarm that matched.
- R7: In latched mode (pulse-mode input 0), the interrupt output is low while at least one flag whose interrupt enable is 1 is set. It returns high once all such flags are cleared.
- R8: An alarm whose interrupt enable is 0 still sets its flag but does not pull the interrupt output low.
- R9: In pulse mode (pulse-mode input 1), each hit of an interrupt-enabled alarm drives the interrupt output low for exactly PULSE_CYC clock cycles, starting after the strobe edge. The output is then released whatever the flags hold.
- R10: After reset, both flags are 0 and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle per-second strobe from the calendar counter |
| cur_time_i | input | 29 | Current time and calendar fields |
| alm_time_i | input | 58 | Alarm values, alarm 0 in the low 29 bits |
| alm_fen_i | input | 12 | Field enables, six per alarm, alarm 0 in the low bits |
| alm_irq_en_i | input | 2 | Per-alarm interrupt enable |
| pulse_mode_i | input | 1 | 1 selects pulse interrupt, 0 selects latched |
| flag_clr_i | input | 2 | Write-one-to-clear strobe per flag |
| flag_o | output | 2 | Sticky alarm flags |
| irq_n_o | output | 1 | Active-low interrupt; 0 means the pad pulls low |

## Verification
A corrupted flag register shows up at flag_o one cycle after the strobe edge that should have set it. It also shows up if a flag drops without a clear, and it then persists until the next clear. A wrong field mask or comparator shows up only on a strobe where that field separates a hit from a miss, so the directed cases move one field at a time around a programmed value. A wrong pulse counter appears on irq_n_o as a low window of the wrong length, visible within PULSE_CYC+1 cycles of the hit. A wrong mask on the latched path leaves irq_n_o low after the last enabled flag is cleared.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int DATE_W = 5;
  localparam int MON_W  = 4;
  localparam int WDAY_W = 3;
  localparam int NFIELD = 6;
  localparam int TIME_W = SEC_W + MIN_W + HR_W + DATE_W + MON_W + WDAY_W;

  // seconds occupy the least significant bits
  typedef struct packed {
    logic [WDAY_W-1:0] wday;
    logic [MON_W-1:0]  mon;
    logic [DATE_W-1:0] date;
    logic [HR_W-1:0]   hr;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HR = 3'd2,
    F_DATE = 3'd3, F_MON = 3'd4, F_WDAY = 3'd5
  } field_idx_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  cal_time_t         cur_i,
  input  cal_time_t         ref_i,
  input  logic [NFIELD-1:0] fen_i,
  output logic              hit_o
);
  logic [NFIELD-1:0] field_eq;

  always_comb begin
    field_eq         = '0;
    field_eq[F_SEC]  = (cur_i.sec  == ref_i.sec);
    field_eq[F_MIN]  = (cur_i.min  == ref_i.min);
    field_eq[F_HR]   = (cur_i.hr   == ref_i.hr);
    field_eq[F_DATE] = (cur_i.date == ref_i.date);
    field_eq[F_MON]  = (cur_i.mon  == ref_i.mon);
    field_eq[F_WDAY] = (cur_i.wday == ref_i.wday);
  end

  // an empty mask must never match
  assign hit_o = (|fen_i) && (&(field_eq | ~fen_i));
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;   // a new hit outranks a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = trig_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (trig_i)              cnt_d = LOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/cal_alarm_pair.sv
module cal_alarm_pair
  import cal_alarm_pkg::*;
#(
  parameter int NUM_ALM   = 2,
  parameter int PULSE_CYC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_tick_i,
  input  logic [TIME_W-1:0]         cur_time_i,
  input  logic [NUM_ALM*TIME_W-1:0] alm_time_i,
  input  logic [NUM_ALM*NFIELD-1:0] alm_fen_i,
  input  logic [NUM_ALM-1:0]        alm_irq_en_i,
  input  logic                      pulse_mode_i,
  input  logic [NUM_ALM-1:0]        flag_clr_i,
  output logic [NUM_ALM-1:0]        flag_o,
  output logic                      irq_n_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cal_time_t          cur_t;
  logic [NUM_ALM-1:0] hit;
  logic [NUM_ALM-1:0] set_vec;

  assign cur_t = cal_time_t'(cur_time_i);

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    cal_time_t ref_t;
    assign ref_t = cal_time_t'(alm_time_i[a*TIME_W +: TIME_W]);

    alarm_match u_match (
      .cur_i (cur_t),
      .ref_i (ref_t),
      .fen_i (alm_fen_i[a*NFIELD +: NFIELD]),
      .hit_o (hit[a])
    );

    assign set_vec[a] = sec_tick_i && hit[a];

    alarm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .set_i  (set_vec[a]),
      .clr_i  (flag_clr_i[a]),
      .flag_o (flag_o[a])
    );
  end

  logic pulse_trig, pulse_active, latched_req, irq_req;

  assign pulse_trig  = |(set_vec & alm_irq_en_i);
  assign latched_req = |(flag_o & alm_irq_en_i);

  irq_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .trig_i   (pulse_trig),
    .active_o (pulse_active)
  );

  assign irq_req = pulse_mode_i ? pulse_active : latched_req;
  assign irq_n_o = ~irq_req;
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk
  import cal_alarm_pkg::*;
#(
  parameter int NUM_ALM   = 2,
  parameter int PULSE_CYC = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sec_tick_i,
  input logic [NUM_ALM*NFIELD-1:0] alm_fen_i,
  input logic [NUM_ALM-1:0]        alm_irq_en_i,
  input logic                      pulse_mode_i,
  input logic [NUM_ALM-1:0]        flag_clr_i,
  input logic [NUM_ALM-1:0]        flag_o,
  input logic                      irq_n_o
);
  for (genvar a = 0; a < NUM_ALM; a++) begin : g_a
    // R5: a set flag only drops after a clear
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[a] && !flag_clr_i[a] |=> flag_o[a]);
    // R4: no strobe, no new flag
    p_no_tick_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_o[a] && !sec_tick_i |=> !flag_o[a]);
    // R3: empty mask never fires
    p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_o[a] && (alm_fen_i[a*NFIELD +: NFIELD] == '0) |=> !flag_o[a]);
  end

  // R7: latched mode, enabled flag set means interrupt low
  p_latched_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_mode_i && ((flag_o & alm_irq_en_i) != '0) |-> !irq_n_o);
  // R8: latched mode, nothing enabled and set means released
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_mode_i && ((flag_o & alm_irq_en_i) == '0) |-> irq_n_o);

  // R9: low window after a strobe never exceeds PULSE_CYC
  localparam int CW = $clog2(PULSE_CYC + 2);
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       low_cnt <= '0;
    else if (sec_tick_i)              low_cnt <= '0;
    else if (pulse_mode_i && !irq_n_o && low_cnt <= CW'(PULSE_CYC))
                                      low_cnt <= low_cnt + 1'b1;
  end
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CW'(PULSE_CYC));
endmodule

bind cal_alarm_pair alarm_chk #(.NUM_ALM(NUM_ALM), .PULSE_CYC(PULSE_CYC)) u_alarm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_tick_i   (sec_tick_i),
  .alm_fen_i    (alm_fen_i),
  .alm_irq_en_i (alm_irq_en_i),
  .pulse_mode_i (pulse_mode_i),
  .flag_clr_i   (flag_clr_i),
  .flag_o       (flag_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/tb_cal_alarm_pair.sv
module tb_cal_alarm_pair;
  import cal_alarm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 2;
  localparam int PC = 8;

  logic                 clk;
  logic                 rst_n;
  logic                 sec_tick_i;
  logic [TIME_W-1:0]    cur_time_i;
  logic [NA*TIME_W-1:0] alm_time_i;
  logic [NA*NFIELD-1:0] alm_fen_i;
  logic [NA-1:0]        alm_irq_en_i;
  logic                 pulse_mode_i;
  logic [NA-1:0]        flag_clr_i;
  logic [NA-1:0]        flag_o;
  logic                 irq_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cal_alarm_pair #(.NUM_ALM(NA), .PULSE_CYC(PC)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic cal_time_t mk(int s, int m, int h, int d, int mo, int w);
    cal_time_t t;
    t.sec = SEC_W'(s); t.min = MIN_W'(m); t.hr = HR_W'(h);
    t.date = DATE_W'(d); t.mon = MON_W'(mo); t.wday = WDAY_W'(w);
    return t;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(int a, cal_time_t t, logic [5:0] fen);
    alm_time_i[a*TIME_W +: TIME_W] = t;
    alm_fen_i[a*NFIELD +: NFIELD]  = fen;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick_i = 1'b1;
    @(negedge clk) sec_tick_i = 1'b0;
  endtask

  task automatic clr(logic [NA-1:0] m);
    @(negedge clk) flag_clr_i = m;
    @(negedge clk) flag_clr_i = '0;
  endtask

  task automatic idle_all();
    alm_fen_i = '0; alm_irq_en_i = '0; pulse_mode_i = 1'b0;
    clr('1);
  endtask

  task automatic t_reset();
    chk("R10 flags", 32'(flag_o), 0);
    chk("R10 irq_n", 32'(irq_n_o), 1);
  endtask

  task automatic t_exact();
    cal_time_t t = mk(23, 5, 5, 21, 3, 2);
    prog(0, t, 6'h3F);
    cur_time_i = t; tick();
    chk("R1 exact hit", 32'(flag_o[0]), 1);
    clr(2'b01);
    cur_time_i = mk(23, 5, 5, 22, 3, 2); tick();
    chk("R1 date mismatch", 32'(flag_o[0]), 0);
    cur_time_i = mk(23, 5, 5, 21, 3, 3); tick();
    chk("R1 wday mismatch", 32'(flag_o[0]), 0);
    idle_all();
  endtask

  task automatic t_recurring();
    prog(0, mk(0, 0, 0, 1, 1, 0), 6'b000001);
    cur_time_i = mk(0, 17, 9, 4, 7, 5); tick();
    chk("R2 seconds only hit", 32'(flag_o[0]), 1);
    clr(2'b01);
    cur_time_i = mk(0, 18, 9, 4, 7, 5); tick();
    chk("R2 next minute hit", 32'(flag_o[0]), 1);
    clr(2'b01);
    cur_time_i = mk(1, 18, 9, 4, 7, 5); tick();
    chk("R2 seconds differ", 32'(flag_o[0]), 0);
    // every given weekday
    prog(0, mk(0, 0, 0, 1, 1, 2), 6'b100000);
    cur_time_i = mk(44, 3, 20, 9, 11, 2); tick();
    chk("R2 weekday only hit", 32'(flag_o[0]), 1);
    idle_all();
  endtask

  task automatic t_empty();
    cal_time_t t = mk(7, 7, 7, 7, 7, 7);
    prog(1, t, 6'b0);
    cur_time_i = t; tick(); tick();
    chk("R3 empty mask", 32'(flag_o[1]), 0);
    idle_all();
  endtask

  task automatic t_no_tick();
    cal_time_t t = mk(10, 20, 3, 15, 6, 1);
    prog(0, t, 6'h3F);
    cur_time_i = t;
    repeat (5) @(negedge clk);
    chk("R4 no strobe", 32'(flag_o[0]), 0);
    tick();
    chk("R4 strobe", 32'(flag_o[0]), 1);
    idle_all();
  endtask

  task automatic t_sticky();
    cal_time_t t = mk(30, 30, 12, 1, 1, 0);
    prog(0, t, 6'h3F);
    cur_time_i = t; tick();
    cur_time_i = mk(31, 30, 12, 1, 1, 0);
    repeat (6) @(negedge clk);
    chk("R5 holds", 32'(flag_o[0]), 1);
    clr(2'b10);
    chk("R5 other clear", 32'(flag_o[0]), 1);
    clr(2'b01);
    chk("R5 cleared", 32'(flag_o[0]), 0);
    cur_time_i = t;
    @(negedge clk) begin sec_tick_i = 1'b1; flag_clr_i = 2'b01; end
    @(negedge clk) begin sec_tick_i = 1'b0; flag_clr_i = 2'b00; end
    chk("R5 set beats clear", 32'(flag_o[0]), 1);
    idle_all();
  endtask

  task automatic t_indep();
    prog(0, mk(5, 0, 0, 1, 1, 0), 6'b000001);
    prog(1, mk(9, 0, 0, 1, 1, 0), 6'b000001);
    cur_time_i = mk(5, 0, 0, 1, 1, 0); tick();
    chk("R6 only alarm0", 32'(flag_o), 32'b01);
    cur_time_i = mk(9, 0, 0, 1, 1, 0); tick();
    chk("R6 alarm1 added", 32'(flag_o), 32'b11);
    clr(2'b01);
    chk("R6 clear alarm0 only", 32'(flag_o), 32'b10);
    idle_all();
  endtask

  task automatic t_latched();
    alm_irq_en_i = 2'b11;
    prog(0, mk(5, 0, 0, 1, 1, 0), 6'b000001);
    prog(1, mk(9, 0, 0, 1, 1, 0), 6'b000001);
    cur_time_i = mk(5, 0, 0, 1, 1, 0); tick();
    chk("R7 low on flag0", 32'(irq_n_o), 0);
    cur_time_i = mk(9, 0, 0, 1, 1, 0); tick();
    clr(2'b01);
    chk("R7 low while flag1", 32'(irq_n_o), 0);
    clr(2'b10);
    chk("R7 released", 32'(irq_n_o), 1);
    idle_all();
  endtask

  task automatic t_mask();
    alm_irq_en_i = 2'b01;
    prog(1, mk(9, 0, 0, 1, 1, 0), 6'b000001);
    cur_time_i = mk(9, 0, 0, 1, 1, 0); tick();
    chk("R8 flag set", 32'(flag_o[1]), 1);
    chk("R8 irq stays high", 32'(irq_n_o), 1);
    idle_all();
  endtask

  task automatic t_pulse();
    int lows = 0;
    int first_high = -1;
    pulse_mode_i = 1'b1; alm_irq_en_i = 2'b01;
    prog(0, mk(5, 0, 0, 1, 1, 0), 6'b000001);
    cur_time_i = mk(5, 0, 0, 1, 1, 0); tick();
    for (int i = 0; i < PC + 3; i++) begin
      if (!irq_n_o) lows++;
      else if (first_high < 0) first_high = i;
      @(negedge clk);
    end
    chk("R9 low cycles", 32'(lows), 32'(PC));
    chk("R9 release point", 32'(first_high), 32'(PC));
    chk("R9 flag still set", 32'(flag_o[0]), 1);
    chk("R9 released with flag", 32'(irq_n_o), 1);
    idle_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sec_tick_i = 1'b0; cur_time_i = '0; alm_time_i = '0;
    alm_fen_i = '0; alm_irq_en_i = '0; pulse_mode_i = 1'b0; flag_clr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_exact();
    t_recurring();
    t_empty();
    t_no_tick();
    t_sticky();
    t_indep();
    t_latched();
    t_mask();
    t_pulse();
    finish_run();
  end
endmodule